// File: doc/BRIEF.md
# DMA Transfer Descriptor Splitter

This block takes a single transfer request (direction, device address, host address, byte length and first table slot) and breaks it into a run of fixed-format descriptor records. It writes them, one 32-bit word per clock, into a local descriptor memory. Each record covers one chunk of the transfer. Every chunk except the last has the maximum chunk size. The last chunk carries the remainder.

Generation ends when the bytes run out or when the descriptor table is full. The table counts as full when either the number of records produced or the slot index reaches the table depth. On completion the block pulses a done strobe together with the number of records written and the number of bytes they cover. When the table fills early, the caller can therefore resume the rest of the transfer later. Requests with zero length, or with a first slot outside the table, are refused without any write.

Top module: `dma_desc_splitter`

## Requirements
- R1: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is high only when the block is idle and stays low from acceptance until the done pulse has passed.
- R2: Each record covers min(remaining bytes, MAX_CHUNK) bytes. The default MAX_CHUNK is 1048320 (1 MiB minus 256). Source and destination addresses are 64-bit and advance by the chunk size after each record, carrying across bit 32.
- R3: A record is written at word addresses slot*8+0 through slot*8+7, one word per clock, in ascending order with no gaps. The word offsets hold: 0 source bits 31:0, 1 source bits 63:32, 2 destination bits 31:0, 3 destination bits 63:32, 4 control, and 5 to 7 zero.
- R4: The control word equals (chunk bytes >> 2) OR (slot << 18).
- R5: With `reqDir`=0 (host to device) the source is the host address and the destination is the device address. With `reqDir`=1 the two are swapped.
- R6: Generation stops after the record that brings the record count to DEPTH, or the slot index to DEPTH, even if bytes remain. The reported byte count then covers only the written records.
- R7: A request with length 0, or with a first slot of DEPTH or more, causes no write. It ends in a done pulse with `doneErr`=1, count 0 and bytes 0.
- R8: A length whose two low bits are not zero sets `doneWarn`=1 at done but is still processed. Byte counts stay exact, and the control length field takes the truncated dword count.
- R9: `doneValid` is a one-cycle pulse in the cycle after the last word write, or in the cycle after acceptance for a refused request. It carries `doneCount` and `doneBytes`, with `doneErr`=0 and `doneWarn`=0 unless R7 or R8 applies.
- R10: After reset the block is idle: `reqReady`=1, `wrEn`=0, `doneValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqDir | input | 1 | 0 host to device, 1 device to host |
| reqDevAddr | input | ADDR_W | Device-side start address |
| reqHostAddr | input | ADDR_W | Host-side start address |
| reqLen | input | LEN_W | Byte length |
| reqStartIdx | input | LEN_W | First descriptor slot |
| wrEn | output | 1 | Descriptor memory write strobe |
| wrAddr | output | log2(DEPTH)+3 | Word address, slot*8+offset |
| wrData | output | 32 | Word to write |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCount | output | log2(DEPTH+1) | Records written |
| doneBytes | output | LEN_W | Bytes covered by the written records |
| doneErr | output | 1 | Request refused |
| doneWarn | output | 1 | Length not a multiple of 4 |

## Verification
The bench builds the block with MAX_CHUNK=64 and DEPTH=8. With these values, requests of a few hundred bytes already split into several chunks. Both stop limits, the record count and the slot index, are reached within a handful of records. At the default sizes the same behaviour would need megabyte lengths and 128 records. A chunk that is not a multiple of 4 and an address that carries into the upper word are also reached with short runs.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // capture request
    logic       emit;     // a descriptor word is written this cycle
    logic       advance;  // last word of the record, step to next chunk
    logic [2:0] word;     // word offset within the record
  } splitStrobe_t;

  localparam int unsigned WORDS_PER_DESC = 8;
  localparam int unsigned WORD_W         = 32;

endpackage

// File: rtl/splitter_ctrl.sv
module splitter_ctrl
  import splitter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         reqBad,
  input  logic         stopNow,
  output splitStrobe_t strobe,
  output logic         doneValid
);

  splitState_t state;
  logic [2:0]  wordCnt;
  logic        accept;
  logic        lastWord;

  assign reqReady  = (state == ST_IDLE);
  assign accept    = reqValid && reqReady;
  assign lastWord  = (wordCnt == 3'd7);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    strobe.load    = accept;
    strobe.emit    = (state == ST_EMIT);
    strobe.advance = (state == ST_EMIT) && lastWord;
    strobe.word    = wordCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          wordCnt <= '0;
          if (accept) state <= reqBad ? ST_DONE : ST_EMIT;
        end
        ST_EMIT: begin
          wordCnt <= wordCnt + 3'd1;
          if (lastWord && stopNow) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: words of one record come on consecutive cycles in ascending order
  a_r3_word_order: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !lastWord) |=> (strobe.emit && strobe.word == $past(strobe.word) + 3'd1));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R1: no request is taken while a record is being emitted
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> !reqReady);

endmodule

// File: rtl/splitter_path.sv
module splitter_path
  import splitter_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned LEN_W     = 32,
  parameter int unsigned MAX_CHUNK = 1048320,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned ID_SHIFT  = 18,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  splitStrobe_t          strobe,
  input  logic                  reqDir,
  input  logic [ADDR_W-1:0]     reqDevAddr,
  input  logic [ADDR_W-1:0]     reqHostAddr,
  input  logic [LEN_W-1:0]      reqLen,
  input  logic [LEN_W-1:0]      reqStartIdx,
  output logic                  reqBad,
  output logic                  stopNow,
  output logic                  wrEn,
  output logic [IDX_W+2:0]      wrAddr,
  output logic [WORD_W-1:0]     wrData,
  output logic [CW-1:0]         doneCount,
  output logic [LEN_W-1:0]      doneBytes,
  output logic                  doneErr,
  output logic                  doneWarn
);

  localparam logic [LEN_W-1:0] MAX_C = LEN_W'(MAX_CHUNK);
  localparam logic [CW-1:0]    LIMIT = CW'(DEPTH);

  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [LEN_W-1:0]  remain, bytesDone, chunk;
  logic [CW-1:0]     descCount, curIdx;
  logic              errReg, warnReg;
  logic [WORD_W-1:0] ctrlWord;

  assign reqBad  = (reqLen == '0) || (reqStartIdx >= LEN_W'(DEPTH));
  assign chunk   = (remain > MAX_C) ? MAX_C : remain;
  assign stopNow = (remain <= MAX_C) ||
                   ((descCount + CW'(1)) == LIMIT) ||
                   ((curIdx + CW'(1)) == LIMIT);

  assign ctrlWord = WORD_W'(chunk >> 2) | (WORD_W'(curIdx) << ID_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      remain    <= '0;
      bytesDone <= '0;
      descCount <= '0;
      curIdx    <= '0;
      errReg    <= 1'b0;
      warnReg   <= 1'b0;
    end else if (strobe.load) begin
      srcAddr   <= reqDir ? reqDevAddr  : reqHostAddr;
      dstAddr   <= reqDir ? reqHostAddr : reqDevAddr;
      remain    <= reqLen;
      bytesDone <= '0;
      descCount <= '0;
      curIdx    <= reqBad ? '0 : reqStartIdx[CW-1:0];
      errReg    <= reqBad;
      warnReg   <= (reqLen[1:0] != 2'b00);
    end else if (strobe.advance) begin
      srcAddr   <= srcAddr + ADDR_W'(chunk);
      dstAddr   <= dstAddr + ADDR_W'(chunk);
      remain    <= remain - chunk;
      bytesDone <= bytesDone + chunk;
      descCount <= descCount + CW'(1);
      curIdx    <= curIdx + CW'(1);
    end
  end

  always_comb begin
    case (strobe.word)
      3'd0:    wrData = srcAddr[31:0];
      3'd1:    wrData = WORD_W'(srcAddr >> 32);
      3'd2:    wrData = dstAddr[31:0];
      3'd3:    wrData = WORD_W'(dstAddr >> 32);
      3'd4:    wrData = ctrlWord;
      default: wrData = '0;
    endcase
  end

  assign wrEn      = strobe.emit;
  assign wrAddr    = {curIdx[IDX_W-1:0], strobe.word};
  assign doneCount = descCount;
  assign doneBytes = bytesDone;
  assign doneErr   = errReg;
  assign doneWarn  = warnReg;

  // R2: every emitted record covers a non-empty chunk
  a_r2_chunk_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (chunk != '0));

  // R6: the record count never passes the table depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    descCount <= LIMIT);

  // R6: a slot outside the table is never written
  a_r6_slot_in_table: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> (curIdx < LIMIT));

endmodule

// File: rtl/dma_desc_splitter.sv
module dma_desc_splitter
  import splitter_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned LEN_W     = 32,
  parameter int unsigned MAX_CHUNK = 1048320,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned ID_SHIFT  = 18,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqDir,
  input  logic [ADDR_W-1:0] reqDevAddr,
  input  logic [ADDR_W-1:0] reqHostAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [LEN_W-1:0]  reqStartIdx,
  output logic              wrEn,
  output logic [IDX_W+2:0]  wrAddr,
  output logic [31:0]       wrData,
  output logic              doneValid,
  output logic [CW-1:0]     doneCount,
  output logic [LEN_W-1:0]  doneBytes,
  output logic              doneErr,
  output logic              doneWarn
);

  splitStrobe_t strobe;
  logic         reqBad;
  logic         stopNow;

  splitter_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqBad    (reqBad),
    .stopNow   (stopNow),
    .strobe    (strobe),
    .doneValid (doneValid)
  );

  splitter_path #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_CHUNK (MAX_CHUNK),
    .DEPTH     (DEPTH),
    .ID_SHIFT  (ID_SHIFT)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqDir      (reqDir),
    .reqDevAddr  (reqDevAddr),
    .reqHostAddr (reqHostAddr),
    .reqLen      (reqLen),
    .reqStartIdx (reqStartIdx),
    .reqBad      (reqBad),
    .stopNow     (stopNow),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .doneCount   (doneCount),
    .doneBytes   (doneBytes),
    .doneErr     (doneErr),
    .doneWarn    (doneWarn)
  );

  // R7: a refused request reports nothing produced
  a_r7_refused_empty: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr) |-> (doneCount == '0 && doneBytes == '0));

  // R9: no descriptor write coincides with completion
  a_r9_done_after_writes: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !wrEn);

endmodule

// File: tb/test_dma_desc_splitter.sv
module test_dma_desc_splitter;

  localparam int unsigned MAXC  = 64;
  localparam int unsigned DEP   = 8;
  localparam int unsigned IDXW  = $clog2(DEP);
  localparam int unsigned CW    = $clog2(DEP + 1);
  localparam int unsigned NWMAX = DEP * 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic            reqDir = 1'b0;
  logic [63:0]     reqDevAddr = '0;
  logic [63:0]     reqHostAddr = '0;
  logic [31:0]     reqLen = '0;
  logic [31:0]     reqStartIdx = '0;
  logic            wrEn;
  logic [IDXW+2:0] wrAddr;
  logic [31:0]     wrData;
  logic            doneValid;
  logic [CW-1:0]   doneCount;
  logic [31:0]     doneBytes;
  logic            doneErr;
  logic            doneWarn;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dma_desc_splitter #(
    .MAX_CHUNK (MAXC),
    .DEPTH     (DEP)
  ) i_dma_desc_splitter (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqDir      (reqDir),
    .reqDevAddr  (reqDevAddr),
    .reqHostAddr (reqHostAddr),
    .reqLen      (reqLen),
    .reqStartIdx (reqStartIdx),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .doneValid   (doneValid),
    .doneCount   (doneCount),
    .doneBytes   (doneBytes),
    .doneErr     (doneErr),
    .doneWarn    (doneWarn)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; model computes expected records, then compares the port trace
  task automatic runReq(input string tag, input logic dir,
                        input logic [63:0] dev, input logic [63:0] host,
                        input logic [31:0] len, input logic [31:0] sidx);
    logic [63:0] exAddr [NWMAX];
    logic [31:0] exData [NWMAX];
    logic [63:0] lgAddr [NWMAX];
    logic [31:0] lgData [NWMAX];
    int          lgSamp [NWMAX];
    int          nEx = 0, nW = 0, s = 1, doneS = 0, busyReady = 0;
    logic        expErr, expWarn, gotDone = 1'b0;
    logic [63:0] src, dst;
    logic [31:0] rem, ch, byt = 0, cnt = 0, idx;
    logic [CW-1:0] gCount = '0;
    logic [31:0] gBytes = '0;
    logic        gErr = 1'b0, gWarn = 1'b0;

    expErr  = (len == 0) || (sidx >= DEP);
    expWarn = (len[1:0] != 2'b00);
    if (!expErr) begin
      src = dir ? dev : host;
      dst = dir ? host : dev;
      rem = len;
      idx = sidx;
      while (1) begin
        ch = (rem > MAXC) ? MAXC : rem;
        for (int w = 0; w < 8; w++) begin
          exAddr[nEx] = 64'(idx * 8 + w);
          case (w)
            0: exData[nEx] = src[31:0];
            1: exData[nEx] = src[63:32];
            2: exData[nEx] = dst[31:0];
            3: exData[nEx] = dst[63:32];
            4: exData[nEx] = (ch >> 2) | (idx << 18);
            default: exData[nEx] = 32'h0;
          endcase
          nEx++;
        end
        cnt++; byt += ch; rem -= ch; idx++;
        src += 64'(ch); dst += 64'(ch);
        if (rem == 0 || cnt == DEP || idx == DEP) break;
      end
    end

    @(negedge clk);
    chk("R1", {tag, " ready before request"}, 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqDir = dir; reqDevAddr = dev; reqHostAddr = host;
    reqLen = len; reqStartIdx = sidx;
    @(negedge clk);
    reqValid = 1'b0;
    while (!gotDone && s < 400) begin
      if (reqReady) busyReady++;
      if (wrEn && nW < NWMAX) begin
        lgAddr[nW] = 64'(wrAddr); lgData[nW] = wrData; lgSamp[nW] = s; nW++;
      end
      if (doneValid) begin
        gotDone = 1'b1; doneS = s;
        gCount = doneCount; gBytes = doneBytes; gErr = doneErr; gWarn = doneWarn;
      end else begin
        @(negedge clk);
        s++;
      end
    end

    chk("R9", {tag, " done seen"}, 64'(gotDone), 64'd1);
    chk("R1", {tag, " ready low while busy"}, 64'(busyReady), 64'd0);
    chk("R3", {tag, " word count"}, 64'(nW), 64'(nEx));
    for (int k = 0; k < nEx && k < nW; k++) begin
      string r;
      r = (k % 8 == 4) ? "R4" : ((k % 8) < 4 ? "R2/R3/R5" : "R3");
      chk(r, $sformatf("%s word %0d addr", tag, k), lgAddr[k], exAddr[k]);
      chk(r, $sformatf("%s word %0d data", tag, k), 64'(lgData[k]), 64'(exData[k]));
      chk("R3", $sformatf("%s word %0d cycle", tag, k), 64'(lgSamp[k]), 64'(k + 1));
    end
    chk("R9", {tag, " done cycle"}, 64'(doneS), 64'(nEx + 1));
    chk(expErr ? "R7" : "R6/R9", {tag, " done count"}, 64'(gCount), 64'(cnt));
    chk(expErr ? "R7" : "R6/R8", {tag, " done bytes"}, 64'(gBytes), 64'(byt));
    chk("R7", {tag, " done err"}, 64'(gErr), 64'(expErr));
    chk("R8", {tag, " done warn"}, 64'(expErr ? gWarn : gWarn), 64'(expWarn));
    @(negedge clk);
    chk("R9", {tag, " done one cycle"}, 64'(doneValid), 64'd0);
    chk("R1", {tag, " ready after done"}, 64'(reqReady), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R10", "ready in reset-release", 64'(reqReady), 64'd1);
    chk("R10", "no write after reset", 64'(wrEn), 64'd0);
    chk("R10", "no done after reset", 64'(doneValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    // R5 R3 R4: host to device, single chunk
    runReq("h2d single", 1'b0, 64'h0000_0001_2000_0000, 64'h0000_0000_8000_1000, 32'd40, 32'd0);
    // R2 R5: device to host, several chunks with remainder
    runReq("d2h multi", 1'b1, 64'h0000_0000_7000_0000, 64'h0000_0002_0000_0100, 32'd200, 32'd2);
    // R2: exact multiple of the chunk size
    runReq("exact", 1'b0, 64'h100, 64'h200, 32'd128, 32'd1);
    // R6: slot index reaches the table end
    runReq("idx limit", 1'b0, 64'h4000, 64'h8000, 32'd1000, 32'd5);
    // R6: record count reaches the table depth
    runReq("count limit", 1'b1, 64'h4000, 64'h8000, 32'd1000, 32'd0);
    // R7: refused requests
    runReq("zero len", 1'b0, 64'h10, 64'h20, 32'd0, 32'd0);
    runReq("bad idx", 1'b0, 64'h10, 64'h20, 32'd64, 32'd8);
    // R8: unaligned length
    runReq("unaligned", 1'b1, 64'h30, 64'h40, 32'd70, 32'd3);
    // R2: carry into the upper address word
    runReq("carry", 1'b0, 64'h0000_0000_FFFF_FFE0, 64'h0000_0003_FFFF_FFF0, 32'd96, 32'd6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule